// File: doc/BRIEF.md
# Single-Bank Row-Buffer Command Sequencer

This block sits between a memory request scheduler and one DRAM bank. It accepts one read or write request at a time (row and column), and turns it into the bank command stream: row activation, column read or write, precharge, refresh, and self-refresh entry and exit. It keeps the bank's row-buffer state and reports it to the scheduler, so that the scheduler can favour requests that hit the open row.

The row-buffer policy is chosen by a static mode input. With the keep-open policy the row stays in the row buffer after an access, and only a row change costs a precharge and an activation. With the auto-close policy every column command is followed at once by a precharge. Minimum spacings (activate to column, precharge to activate, activate to activate, write to read, self-refresh exit) are enforced with cycle counters set by elaboration parameters. Refresh is spread out: one row per interval, from a wrapping row counter, and a refresh that has come due runs before any held request.

Top module: `bank_seq`

## Requirements
- R1: After reset the command output is idle (code 0), no row is reported open, self-refresh is inactive and a request is accepted. Command codes: 0 idle, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh, 6 self-refresh entry, 7 self-refresh exit.
- R2: With close_page low, a request to the row that is currently open issues only its column command, with no activate before it.
- R3: With close_page low, a request to another row first precharges the open row, then activates the new row, then issues the column command. An activate is never issued while a row is open, and a column command always targets the open row.
- R4: With close_page high, the command immediately after each read or write is a precharge.
- R5: A column command comes at least T_RCD cycles after its activate, and an activate at least T_RP cycles after the preceding precharge.
- R6: Two row-opening commands (activate or refresh) are at least T_RC cycles apart.
- R7: A read comes at least T_WTR cycles after the latest write.
- R8: One refresh command is issued per T_REFI-cycle interval, with the row counter on cmd_row stepping by one and wrapping from NUM_ROWS-1 to 0. A refresh that has come due first closes any open row and runs ahead of a held request.
- R9: While sr_req is high and nothing is held, the bank is closed and a self-refresh entry is issued. Only idle codes follow until sr_req falls, then an exit is issued, and no other command follows it within T_XSR cycles.
- R10: row_open and open_row go valid with the row when an activate is issued and row_open clears on precharge, refresh and self-refresh entry.
- R11: Requests are carried out in acceptance order, each read or write carrying the request's row and column. req_ready is low while a request is held, while sr_req is high and during self-refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| close_page | input | 1 | Row policy: 1 auto-close, 0 keep open |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 write, 0 read |
| req_row | input | ROW_W | Request row |
| req_col | input | COL_W | Request column |
| req_ready | output | 1 | Request accepted when valid |
| sr_req | input | 1 | Level: hold the bank in self-refresh |
| cmd_code | output | 3 | Command issued this cycle |
| cmd_row | output | ROW_W | Row of activate, precharge, column or refresh |
| cmd_col | output | COL_W | Column of read or write |
| row_open | output | 1 | A row is open in the row buffer |
| open_row | output | ROW_W | The open row |
| sr_active | output | 1 | Bank is in self-refresh |

## Verification
The two functions that collide are the refresh deadline and a request stream that keeps a row open and changes rows often. A long run of back-to-back requests across alternating rows is driven over several refresh intervals, so deadlines land while a request is held and a row is open. It is judged by the refresh command following a precharge, carrying the next wrapped row, staying within its interval window, and the held request then completing in order after a fresh activate with every spacing still met.

// File: rtl/bank_seq_pkg.sv
package bank_seq_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_REF = 3'd5,
        CMD_SRE = 3'd6,
        CMD_SRX = 3'd7
    } bank_cmd_e;

    function automatic int int_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/bank_seq_timer.sv
module bank_seq_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/bank_seq_refresh.sv
module bank_seq_refresh #(
    parameter int T_REFI   = 1560,
    parameter int NUM_ROWS = 8192,
    parameter int ROW_W    = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic             ack,
    output logic             due,
    output logic [ROW_W-1:0] row
);
    localparam int TW = $clog2(T_REFI);
    localparam logic [TW-1:0]    LAST_TICK = TW'(T_REFI - 1);
    localparam logic [ROW_W-1:0] LAST_ROW  = ROW_W'(NUM_ROWS - 1);

    logic [TW-1:0] tick;

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            tick <= '0;
            due  <= 1'b0;
        end else begin
            if (tick == LAST_TICK) begin
                tick <= '0;
                due  <= 1'b1;
            end else begin
                tick <= tick + 1'b1;
                if (ack) due <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            row <= '0;
        else if (ack)
            row <= (row == LAST_ROW) ? '0 : row + 1'b1;
    end

    // R8: a refresh is only acknowledged when one is due
    a_r8_ack_when_due: assert property (@(posedge clk) disable iff (rst) ack |-> due);
endmodule

// File: rtl/bank_seq.sv
module bank_seq
    import bank_seq_pkg::*;
#(
    parameter int ROW_W    = 14,
    parameter int COL_W    = 10,
    parameter int NUM_ROWS = 8192,
    parameter int T_RCD    = 4,
    parameter int T_RP     = 4,
    parameter int T_RC     = 12,
    parameter int T_WTR    = 6,
    parameter int T_REFI   = 1560,
    parameter int T_XSR    = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             close_page,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    output logic             req_ready,
    input  logic             sr_req,
    output logic [2:0]       cmd_code,
    output logic [ROW_W-1:0] cmd_row,
    output logic [COL_W-1:0] cmd_col,
    output logic             row_open,
    output logic [ROW_W-1:0] open_row,
    output logic             sr_active
);
    localparam int GAP_W = $clog2(int_max(int_max(T_RCD, T_RP), T_XSR) + 1);
    localparam int RC_W  = $clog2(T_RC + 1);
    localparam int WTR_W = $clog2(T_WTR + 1);

    typedef struct packed {
        logic             wr;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
    } bank_req_t;

    bank_req_t        pend;
    logic             pend_v, post_pre, in_sr;
    logic             open_q;
    logic [ROW_W-1:0] open_row_q;
    bank_cmd_e        nxt, cmd_q;
    logic [ROW_W-1:0] nxt_row, cmd_row_q;
    logic [COL_W-1:0] nxt_col, cmd_col_q;
    logic             gap_done, trc_done, wtr_done;
    logic             gap_load;
    logic [GAP_W-1:0] gap_val;
    logic             ref_due;
    logic [ROW_W-1:0] ref_row;
    logic             hit;

    assign hit = open_q && (open_row_q == pend.row);

    // command choice for this cycle
    always_comb begin
        nxt = CMD_NOP;
        if (in_sr) begin
            if (!sr_req) nxt = CMD_SRX;
        end else if (gap_done) begin
            if (post_pre)
                nxt = CMD_PRE;
            else if (ref_due) begin
                if (open_q)        nxt = CMD_PRE;
                else if (trc_done) nxt = CMD_REF;
            end else if (pend_v) begin
                if (hit) begin
                    if (pend.wr)       nxt = CMD_WR;
                    else if (wtr_done) nxt = CMD_RD;
                end else if (open_q)   nxt = CMD_PRE;
                else if (trc_done)     nxt = CMD_ACT;
            end else if (sr_req) begin
                nxt = open_q ? CMD_PRE : CMD_SRE;
            end
        end
    end

    always_comb begin
        nxt_row = '0;
        nxt_col = '0;
        unique case (nxt)
            CMD_ACT:        nxt_row = pend.row;
            CMD_PRE:        nxt_row = open_row_q;
            CMD_REF:        nxt_row = ref_row;
            CMD_RD, CMD_WR: begin
                nxt_row = open_row_q;
                nxt_col = pend.col;
            end
            default: ;
        endcase
    end

    always_comb begin
        gap_load = 1'b1;
        unique case (nxt)
            CMD_ACT: gap_val = GAP_W'(T_RCD - 1);
            CMD_PRE: gap_val = GAP_W'(T_RP - 1);
            CMD_SRX: gap_val = GAP_W'(T_XSR - 1);
            default: begin
                gap_val  = '0;
                gap_load = 1'b0;
            end
        endcase
    end

    bank_seq_timer #(.W(GAP_W)) u_gap (
        .clk(clk), .rst(rst), .load(gap_load), .load_val(gap_val), .done(gap_done)
    );

    bank_seq_timer #(.W(RC_W)) u_trc (
        .clk(clk), .rst(rst), .load(nxt == CMD_ACT || nxt == CMD_REF),
        .load_val(RC_W'(T_RC - 1)), .done(trc_done)
    );

    bank_seq_timer #(.W(WTR_W)) u_wtr (
        .clk(clk), .rst(rst), .load(nxt == CMD_WR),
        .load_val(WTR_W'(T_WTR - 1)), .done(wtr_done)
    );

    bank_seq_refresh #(.T_REFI(T_REFI), .NUM_ROWS(NUM_ROWS), .ROW_W(ROW_W)) u_ref (
        .clk(clk), .rst(rst), .hold(in_sr), .ack(nxt == CMD_REF),
        .due(ref_due), .row(ref_row)
    );

    assign req_ready = !pend_v && !in_sr && !sr_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v     <= 1'b0;
            pend       <= '0;
            post_pre   <= 1'b0;
            in_sr      <= 1'b0;
            open_q     <= 1'b0;
            open_row_q <= '0;
            cmd_q      <= CMD_NOP;
            cmd_row_q  <= '0;
            cmd_col_q  <= '0;
        end else begin
            cmd_q     <= nxt;
            cmd_row_q <= nxt_row;
            cmd_col_q <= nxt_col;
            if (req_valid && req_ready) begin
                pend_v <= 1'b1;
                pend   <= '{wr: req_write, row: req_row, col: req_col};
            end else if (nxt == CMD_RD || nxt == CMD_WR) begin
                pend_v <= 1'b0;
            end
            if ((nxt == CMD_RD || nxt == CMD_WR) && close_page) post_pre <= 1'b1;
            else if (nxt == CMD_PRE)                             post_pre <= 1'b0;
            if (nxt == CMD_SRE)      in_sr <= 1'b1;
            else if (nxt == CMD_SRX) in_sr <= 1'b0;
            if (nxt == CMD_ACT) begin
                open_q     <= 1'b1;
                open_row_q <= pend.row;
            end else if (nxt == CMD_PRE || nxt == CMD_REF || nxt == CMD_SRE) begin
                open_q <= 1'b0;
            end
        end
    end

    assign cmd_code  = cmd_q;
    assign cmd_row   = cmd_row_q;
    assign cmd_col   = cmd_col_q;
    assign row_open  = open_q;
    assign open_row  = open_row_q;
    assign sr_active = in_sr;

    // ---------------- assertions ----------------
    logic [RC_W-1:0]  act_age;
    logic [WTR_W-1:0] wr_age;
    logic             act_seen, wr_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_age <= '0; act_seen <= 1'b0;
            wr_age  <= '0; wr_seen  <= 1'b0;
        end else begin
            if (cmd_code == CMD_ACT || cmd_code == CMD_REF) begin
                act_age  <= RC_W'(1);
                act_seen <= 1'b1;
            end else if (act_age < RC_W'(T_RC)) act_age <= act_age + 1'b1;
            if (cmd_code == CMD_WR) begin
                wr_age  <= WTR_W'(1);
                wr_seen <= 1'b1;
            end else if (wr_age < WTR_W'(T_WTR)) wr_age <= wr_age + 1'b1;
        end
    end

    a_r6_row_cycle: assert property (@(posedge clk) disable iff (rst)
        ((cmd_code == CMD_ACT || cmd_code == CMD_REF) && act_seen) |-> act_age >= RC_W'(T_RC));
    a_r7_wr_to_rd: assert property (@(posedge clk) disable iff (rst)
        (cmd_code == CMD_RD && wr_seen) |-> wr_age >= WTR_W'(T_WTR));
    a_r4_auto_close: assert property (@(posedge clk) disable iff (rst)
        (close_page && (cmd_code == CMD_RD || cmd_code == CMD_WR)) |=> cmd_code == CMD_PRE);
    a_r10_open_on_act: assert property (@(posedge clk) disable iff (rst)
        cmd_code == CMD_ACT |-> (row_open && open_row == cmd_row));
    a_r10_closed: assert property (@(posedge clk) disable iff (rst)
        (cmd_code == CMD_PRE || cmd_code == CMD_REF || cmd_code == CMD_SRE) |-> !row_open);
    a_r9_quiet_in_sr: assert property (@(posedge clk) disable iff (rst)
        sr_active |-> (cmd_code == CMD_NOP || cmd_code == CMD_SRE));
    a_r11_no_ready_in_sr: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !sr_active);
endmodule

// File: tb/bank_seq_tb.sv
module bank_seq_tb;
    localparam int ROW_W = 4, COL_W = 4, NUM_ROWS = 4;
    localparam int T_RCD = 3, T_RP = 2, T_RC = 6, T_WTR = 4, T_REFI = 150, T_XSR = 10;
    localparam logic [2:0] C_NOP = 0, C_ACT = 1, C_RD = 2, C_WR = 3,
                           C_PRE = 4, C_REF = 5, C_SRE = 6, C_SRX = 7;

    logic clk = 0, rst = 1, close_page = 0, req_valid = 0, req_write = 0, sr_req = 0;
    logic [ROW_W-1:0] req_row = '0;
    logic [COL_W-1:0] req_col = '0;
    logic req_ready, row_open, sr_active;
    logic [2:0] cmd_code;
    logic [ROW_W-1:0] cmd_row, open_row;
    logic [COL_W-1:0] cmd_col;

    always #2 clk = ~clk;

    bank_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .NUM_ROWS(NUM_ROWS), .T_RCD(T_RCD),
               .T_RP(T_RP), .T_RC(T_RC), .T_WTR(T_WTR), .T_REFI(T_REFI), .T_XSR(T_XSR)) u_dut (
        .clk(clk), .rst(rst), .close_page(close_page), .req_valid(req_valid),
        .req_write(req_write), .req_row(req_row), .req_col(req_col), .req_ready(req_ready),
        .sr_req(sr_req), .cmd_code(cmd_code), .cmd_row(cmd_row), .cmd_col(cmd_col),
        .row_open(row_open), .open_row(open_row), .sr_active(sr_active));

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    logic [2+ROW_W+COL_W-1:0] exp_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // driver: hand over one request and push its expected column command
    task automatic send(input bit wr, input int row, input int col);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_write = wr;
        req_row = ROW_W'(row); req_col = COL_W'(col);
        exp_q.push_back({(wr ? C_WR : C_RD), ROW_W'(row), COL_W'(col)});
        @(negedge clk);
        req_valid = 0;
    endtask

    // monitor: scoreboard pops plus port-level rule checks
    int cyc = 0, n_act = 0, n_ref = 0, n_pre = 0;
    int last_act = -1000, last_pre = -1000, last_opn = -1000, last_wr = -1000;
    int last_ref = -1, last_srx = -1;
    bit m_open = 0, expect_pre = 0, chk_xsr = 0, sr_between = 0, xsr_seen = 0;
    logic [ROW_W-1:0] m_row = '0;
    int ref_exp = 0;

    always @(negedge clk) begin
        if (!rst) begin
            cyc++;
            if (sr_active)
                chk(cmd_code == C_NOP || cmd_code == C_SRE, "R9", "command in self-refresh",
                    cmd_code, C_NOP);
            if (cmd_code != C_NOP) begin
                if (expect_pre) begin
                    chk(cmd_code == C_PRE, "R4", "command after column", cmd_code, C_PRE);
                    expect_pre = 0;
                end
                if (chk_xsr && cmd_code != C_SRX) begin
                    chk(cyc - last_srx >= T_XSR, "R9", "exit gap", cyc - last_srx, T_XSR);
                    chk_xsr = 0; xsr_seen = 1;
                end
                case (cmd_code)
                    C_ACT: begin
                        chk(!m_open, "R3", "activate with row open", m_open, 0);
                        chk(cyc - last_pre >= T_RP, "R5", "pre to act", cyc - last_pre, T_RP);
                        chk(cyc - last_opn >= T_RC, "R6", "act spacing", cyc - last_opn, T_RC);
                        chk(row_open && open_row == cmd_row, "R10", "status on act",
                            open_row, cmd_row);
                        m_open = 1; m_row = cmd_row; n_act++;
                        last_act = cyc; last_opn = cyc;
                    end
                    C_RD, C_WR: begin
                        logic [2+ROW_W+COL_W-1:0] e;
                        chk(m_open && cmd_row == m_row, "R3", "column row", cmd_row, m_row);
                        chk(cyc - last_act >= T_RCD, "R5", "act to col", cyc - last_act, T_RCD);
                        if (cmd_code == C_RD)
                            chk(cyc - last_wr >= T_WTR, "R7", "wr to rd", cyc - last_wr, T_WTR);
                        else last_wr = cyc;
                        if (exp_q.size() == 0) chk(0, "R11", "unexpected column", cmd_code, 0);
                        else begin
                            e = exp_q.pop_front();
                            chk(e == {cmd_code, cmd_row, cmd_col}, "R11", "column cmd",
                                int'({cmd_code, cmd_row, cmd_col}), int'(e));
                        end
                        if (close_page) expect_pre = 1;
                    end
                    C_PRE: begin
                        chk(!row_open, "R10", "status on pre", row_open, 0);
                        m_open = 0; last_pre = cyc; n_pre++;
                    end
                    C_REF: begin
                        chk(!m_open, "R8", "refresh with row open", m_open, 0);
                        chk(int'(cmd_row) == ref_exp, "R8", "refresh row", cmd_row, ref_exp);
                        chk(!row_open, "R10", "status on ref", row_open, 0);
                        chk(cyc - last_opn >= T_RC, "R6", "ref spacing", cyc - last_opn, T_RC);
                        if (last_ref >= 0 && !sr_between)
                            chk(cyc - last_ref >= T_REFI - 20 && cyc - last_ref <= T_REFI + 20,
                                "R8", "refresh interval", cyc - last_ref, T_REFI);
                        ref_exp = (ref_exp + 1) % NUM_ROWS;
                        last_ref = cyc; last_opn = cyc; sr_between = 0; n_ref++;
                    end
                    C_SRE: begin
                        chk(!m_open, "R9", "entry with row open", m_open, 0);
                        chk(!row_open, "R10", "status on entry", row_open, 0);
                        sr_between = 1;
                    end
                    C_SRX: begin
                        last_srx = cyc; chk_xsr = 1;
                    end
                    default: ;
                endcase
            end
        end
    end

    task automatic wait_idle();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (12) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "WDOG", "watchdog expired", 0, 1);
        report();
    end

    initial begin
        int a0, r0, p0;
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(cmd_code == C_NOP, "R1", "reset cmd", cmd_code, C_NOP);
        chk(!row_open, "R1", "reset row_open", row_open, 0);
        chk(!sr_active, "R1", "reset sr_active", sr_active, 0);
        chk(req_ready, "R1", "reset ready", req_ready, 1);

        // R2 keep-open hits, with a write then read for R7
        a0 = n_act; r0 = n_ref;
        send(0, 2, 1); send(1, 2, 5); send(0, 2, 7);
        wait_idle();
        chk(n_act - a0 >= 1 && n_act - a0 <= 1 + (n_ref - r0), "R2", "activates on hits",
            n_act - a0, 1);

        // R3 row change
        a0 = n_act; p0 = n_pre; r0 = n_ref;
        send(0, 5, 3);
        wait_idle();
        chk(n_pre - p0 >= 1, "R3", "precharges on conflict", n_pre - p0, 1);
        chk(n_act - a0 >= 1 && n_act - a0 <= 1 + (n_ref - r0), "R3", "activates on conflict",
            n_act - a0, 1);
        chk(row_open && open_row == 4'd5, "R10", "open row after conflict", open_row, 5);

        // R4 auto-close
        close_page = 1;
        a0 = n_act; r0 = n_ref;
        send(1, 5, 2); send(0, 5, 4); send(0, 9, 0);
        wait_idle();
        chk(n_act - a0 >= 2 && n_act - a0 <= 2 + (n_ref - r0), "R4", "activates auto-close",
            n_act - a0, 2);
        chk(!row_open, "R4", "closed after access", row_open, 0);
        close_page = 0;

        // R8 refresh against a busy, row-changing stream
        for (int i = 0; i < 80; i++) send(i % 4 == 3, i % 3, i % 16);
        wait_idle();
        for (int t = 0; t < 2000 && n_ref < 6; t++) @(negedge clk);
        chk(n_ref >= 6, "R8", "refresh count with wrap", n_ref, 6);

        // R9 self-refresh with an open row
        send(0, 7, 2);
        wait_idle();
        sr_req = 1;
        for (int t = 0; t < 100 && !sr_active; t++) @(negedge clk);
        chk(sr_active, "R9", "entered self-refresh", sr_active, 1);
        chk(!row_open, "R10", "closed in self-refresh", row_open, 0);
        chk(!req_ready, "R11", "ready in self-refresh", req_ready, 0);
        repeat (40) @(negedge clk);
        chk(sr_active, "R9", "held in self-refresh", sr_active, 1);
        sr_req = 0;
        send(0, 1, 1);
        wait_idle();
        chk(xsr_seen, "R9", "exit gap observed", xsr_seen, 1);
        chk(exp_q.size() == 0, "R11", "all requests done", exp_q.size(), 0);
        report();
    end
endmodule